// File: doc/BRIEF.md
# Data EEPROM Access Controller

This block sits on a small processor's byte-wide I/O bus and gives software access to a 512-byte nonvolatile data store. The store is modelled inside the block as a synchronous byte memory. Software reaches it through four byte registers: two registers that together hold a 9-bit byte address, a data register, and a control/status register. A control write with the read strobe set fetches one byte into the data register. A control write with the write strobe set, accepted only inside a short window after a guard bit is set, starts a self-timed write of the data register's byte.

Each accepted access freezes the processor for a fixed number of cycles through a hold output. A read holds it for four cycles and a write for two. A write also keeps a busy flag set for a parameterized number of cycles. The byte lands in the array when that count runs out, and software polls the flag before it starts the next access.

Top module: `nvdata_ctrl`

## Requirements
- R1: Register select 0 holds address bits 7:0 and select 1 holds address bit 8 in its bit 0. Both read back what was written. Together they address bytes 0 to 511 linearly.
- R2: Bits 7:1 of the select-1 register ignore writes and always read as zero.
- R3: A control write (select 3) with bit 0 set and bit 1 clear, while not busy, loads the data register (select 2) with the array byte at the current address.
- R4: After an accepted read the hold output is high for exactly 4 consecutive cycles, starting the cycle after the control write.
- R5: After an accepted write the hold output is high for exactly 2 consecutive cycles, starting the cycle after the control write.
- R6: An accepted write sets the busy flag (control bit 3) for exactly WR_CYCLES cycles. The array byte at the address and data captured at acceptance changes when the flag clears.
- R7: A control write with bit 1 set is ignored when no guard was armed: there is no hold, no busy and no array change.
- R8: A control write with bit 2 set arms the guard. A write strobe 1 to 4 cycles later is accepted. A write strobe 5 or more cycles later is ignored.
- R9: While busy, read and write strobes are ignored: there is no hold, the data register is unchanged and the array is unchanged.
- R10: Control bits 0 and 1 always read as zero. Control bit 2 reads 1 while the guard is armed, and an accepted write disarms it.
- R11: After reset the hold output is low, the data register reads 0 and the control register reads 0. The address register has no reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write when high |
| bus_addr | input | 2 | Register select: 0 address low, 1 address high, 2 data, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| cpu_hold | output | 1 | Freezes the processor after an accepted access |

## Verification
Directed writes and reads at addresses 0, 511 and mixed-bit addresses show that both halves of the address reach the array. Guard gaps of 1, 4 and 5 cycles, plus a strobe with no guard at all, separate the accepted window from the rejected one. Strobes issued while a write is still busy show that the pending byte, the data register and other array locations are left alone. Seeded random write/read pairs with random gaps inside the window compare array contents against a bench model, and every accepted access is checked for its hold length and, for writes, its busy length.

// File: rtl/nvdata_pkg.sv
package nvdata_pkg;

    // Register select codes on the I/O bus.
    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA    = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    // Control register bit positions.
    localparam int CTL_RD   = 0;
    localparam int CTL_WR   = 1;
    localparam int CTL_ARM  = 2;
    localparam int CTL_BUSY = 3;

    // Decoded software request from one bus cycle.
    typedef struct packed {
        logic rd;
        logic wr;
        logic arm;
    } ctl_req_t;

    function automatic ctl_req_t decode_ctl(logic hit, logic [7:0] d);
        ctl_req_t r;
        r.rd  = hit & d[CTL_RD];
        r.wr  = hit & d[CTL_WR];
        r.arm = hit & d[CTL_ARM];
        return r;
    endfunction

    // Status byte as software sees it; strobe bits always read zero.
    function automatic logic [7:0] pack_status(logic armed, logic busy);
        logic [7:0] s;
        s = 8'h00;
        s[CTL_ARM]  = armed;
        s[CTL_BUSY] = busy;
        return s;
    endfunction

endpackage

// File: rtl/nvdata_regs.sv
module nvdata_regs
    import nvdata_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int GUARD_WIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              fill,
    input  logic [7:0]        fill_data,
    input  logic              wr_accept,
    input  logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data,
    output logic              guard_armed,
    output ctl_req_t          req,
    output logic [7:0]        bus_rdata
);
    localparam int HI_W = ADDR_W - 8;
    localparam int GW   = $clog2(GUARD_WIN + 1);

    logic              wr_cyc;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [GW-1:0]     guard_cnt;

    assign wr_cyc = bus_sel & bus_we;
    assign req    = decode_ctl(wr_cyc && reg_sel_e'(bus_addr) == SEL_CTRL, bus_wdata);

    // Address holds no reset value by intent.
    always_ff @(posedge clk) begin
        if (wr_cyc && reg_sel_e'(bus_addr) == SEL_ADDR_LO)
            addr_q[7:0] <= bus_wdata;
        if (wr_cyc && reg_sel_e'(bus_addr) == SEL_ADDR_HI)
            addr_q[ADDR_W-1:8] <= bus_wdata[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= 8'h00;
        else if (fill)
            data_q <= fill_data;
        else if (wr_cyc && reg_sel_e'(bus_addr) == SEL_DATA)
            data_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            guard_cnt <= '0;
        else if (wr_accept)
            guard_cnt <= '0;
        else if (req.arm)
            guard_cnt <= GW'(GUARD_WIN);
        else if (guard_cnt != '0)
            guard_cnt <= guard_cnt - 1'b1;
    end

    assign addr        = addr_q;
    assign data        = data_q;
    assign guard_armed = (guard_cnt != '0);

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_ADDR_LO: bus_rdata = addr_q[7:0];
            SEL_ADDR_HI: bus_rdata = {{(8-HI_W){1'b0}}, addr_q[ADDR_W-1:8]};
            SEL_DATA:    bus_rdata = data_q;
            default:     bus_rdata = pack_status(guard_armed, busy);
        endcase
    end
endmodule

// File: rtl/nvdata_seq.sv
module nvdata_seq #(
    parameter int RD_HOLD   = 4,
    parameter int WR_HOLD   = 2,
    parameter int WR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    input  logic guard_armed,
    output logic rd_accept,
    output logic wr_accept,
    output logic fill,
    output logic commit,
    output logic hold,
    output logic busy
);
    localparam int MAX_HOLD = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
    localparam int HW       = $clog2(MAX_HOLD + 1);
    localparam int TW       = $clog2(WR_CYCLES + 1);

    logic [HW-1:0] hold_cnt;
    logic [TW-1:0] tmr;
    logic          fill_q;

    // Write strobe wins when both strobes arrive together.
    assign wr_accept = wr_req & guard_armed & ~busy;
    assign rd_accept = rd_req & ~wr_req & ~busy;

    always_ff @(posedge clk) begin
        if (rst)
            hold_cnt <= '0;
        else if (rd_accept)
            hold_cnt <= HW'(RD_HOLD);
        else if (wr_accept)
            hold_cnt <= HW'(WR_HOLD);
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tmr <= '0;
        else if (wr_accept)
            tmr <= TW'(WR_CYCLES);
        else if (tmr != '0)
            tmr <= tmr - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) fill_q <= 1'b0;
        else     fill_q <= rd_accept;
    end

    assign fill   = fill_q;
    assign hold   = (hold_cnt != '0);
    assign busy   = (tmr != '0);
    assign commit = (tmr == TW'(1));
endmodule

// File: rtl/nvdata_array.sv
module nvdata_array #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              capture,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0]        pend_data;
    logic [7:0]        q;

    // Address and byte are frozen at acceptance for the whole busy period.
    always_ff @(posedge clk) begin
        if (capture) begin
            pend_addr <= addr;
            pend_data <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (commit)
            mem[pend_addr] <= pend_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= 8'h00;
        else if (rd_en)
            q <= mem[addr];
    end

    assign rdata = q;
endmodule

// File: rtl/nvdata_ctrl.sv
module nvdata_ctrl
    import nvdata_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int RD_HOLD   = 4,
    parameter int WR_HOLD   = 2,
    parameter int GUARD_WIN = 4,
    parameter int WR_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       cpu_hold
);
    ctl_req_t          req;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
    logic [7:0]        arr_q;
    logic              guard_armed;
    logic              rd_accept;
    logic              wr_accept;
    logic              fill;
    logic              commit;
    logic              busy;

    nvdata_regs #(.ADDR_W(ADDR_W), .GUARD_WIN(GUARD_WIN)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .fill(fill), .fill_data(arr_q), .wr_accept(wr_accept), .busy(busy),
        .addr(addr), .data(data), .guard_armed(guard_armed), .req(req),
        .bus_rdata(bus_rdata)
    );

    nvdata_seq #(.RD_HOLD(RD_HOLD), .WR_HOLD(WR_HOLD), .WR_CYCLES(WR_CYCLES)) u_seq (
        .clk(clk), .rst(rst),
        .rd_req(req.rd), .wr_req(req.wr), .guard_armed(guard_armed),
        .rd_accept(rd_accept), .wr_accept(wr_accept), .fill(fill),
        .commit(commit), .hold(cpu_hold), .busy(busy)
    );

    nvdata_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst),
        .rd_en(rd_accept), .capture(wr_accept), .commit(commit),
        .addr(addr), .wdata(data), .rdata(arr_q)
    );
endmodule

// File: rtl/nvdata_ctrl_chk.sv
module nvdata_ctrl_chk #(
    parameter int ADDR_W  = 9,
    parameter int RD_HOLD = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       hold,
    input logic       busy,
    input logic       commit,
    input logic       rd_accept,
    input logic       wr_accept,
    input logic       guard_armed,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_rdata
);
    localparam int HI_W = ADDR_W - 8;
    localparam int RW   = $clog2(RD_HOLD + 2);

    logic [RW-1:0] hold_run;

    always_ff @(posedge clk) begin
        if (rst)
            hold_run <= '0;
        else if (hold && hold_run != RW'(RD_HOLD + 1))
            hold_run <= hold_run + 1'b1;
        else if (!hold)
            hold_run <= '0;
    end

    a_r2_hi_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1) |-> ((bus_rdata >> HI_W) == 8'h00));

    a_r3_read_holds: assert property (@(posedge clk) disable iff (rst)
        rd_accept |=> hold);

    a_r3_one_access: assert property (@(posedge clk) disable iff (rst)
        !(rd_accept && wr_accept));

    a_r4_hold_bound: assert property (@(posedge clk) disable iff (rst)
        hold |-> (hold_run < RW'(RD_HOLD)));

    a_r5_write_holds: assert property (@(posedge clk) disable iff (rst)
        wr_accept |=> (hold && busy));

    a_r6_commit_in_busy: assert property (@(posedge clk) disable iff (rst)
        commit |-> busy);

    a_r6_commit_ends: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy);

    a_r8_guard_needed: assert property (@(posedge clk) disable iff (rst)
        wr_accept |-> guard_armed);

    a_r9_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> !$past(busy));

    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hold && !busy));
endmodule

bind nvdata_ctrl nvdata_ctrl_chk #(.ADDR_W(ADDR_W), .RD_HOLD(RD_HOLD)) u_chk (
    .clk(clk), .rst(rst), .hold(cpu_hold), .busy(busy), .commit(commit),
    .rd_accept(rd_accept), .wr_accept(wr_accept), .guard_armed(guard_armed),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/nvdata_ctrl_bench.sv
module nvdata_ctrl_bench;
    localparam int WR_CYC = 64;
    localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_DAT = 2'd2, A_CTL = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [512];

    always #5 clk = ~clk;

    nvdata_ctrl #(.WR_CYCLES(WR_CYC)) u_nvdata_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_hold(cpu_hold)
    );

    function automatic logic [7:0] addr_hi_byte(logic [8:0] a);
        return {7'b0, a[8]};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = A_CTL;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata; bus_addr = A_CTL;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_addr(logic [8:0] a);
        bus_wr(A_LO, a[7:0]);
        bus_wr(A_HI, addr_hi_byte(a));
    endtask

    // Counts hold and busy cycles from the falling edge after a strobe.
    task automatic measure(output int h, output int b);
        logic [7:0] s;
        h = 0; b = 0;
        for (int i = 0; i < WR_CYC + 8; i++) begin
            rd_reg(A_CTL, s);
            if (cpu_hold) h++;
            if (s[3]) b++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(logic [8:0] a, logic [7:0] d, int gap, output int h, output int b);
        set_addr(a);
        bus_wr(A_DAT, d);
        bus_wr(A_CTL, 8'h04);
        idle(gap - 1);
        bus_wr(A_CTL, 8'h02);
        measure(h, b);
    endtask

    task automatic do_read(logic [8:0] a, output int h, output logic [7:0] d);
        set_addr(a);
        bus_wr(A_CTL, 8'h01);
        h = 0;
        for (int i = 0; i < 12; i++) begin
            if (cpu_hold) h++;
            @(negedge clk);
        end
        rd_reg(A_DAT, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0h expected %0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int h, b;
        logic [7:0] d;
        logic [8:0] ra;
        logic [7:0] rv;
        int gap;

        void'($urandom(32'd20240611));
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        check("R11 hold", int'(cpu_hold), 0);
        rd_reg(A_CTL, d); check("R11 ctrl", int'(d), 0);
        rd_reg(A_DAT, d); check("R11 data", int'(d), 0);

        // R1, R2: address registers
        bus_wr(A_LO, 8'hA5);
        bus_wr(A_HI, 8'hFF);
        rd_reg(A_LO, d); check("R1 addr low", int'(d), 'hA5);
        rd_reg(A_HI, d); check("R2 addr high masked", int'(d), 1);
        bus_wr(A_HI, 8'hFE);
        rd_reg(A_HI, d); check("R2 addr high zero", int'(d), 0);

        // R5, R6, R8, R10: accepted writes at boundaries, gaps 1 and 4
        bus_wr(A_CTL, 8'h04);
        rd_reg(A_CTL, d); check("R10 armed readback", int'(d), 'h04);
        idle(6);
        rd_reg(A_CTL, d); check("R10 disarmed after window", int'(d), 0);

        do_write(9'd0, 8'h5A, 1, h, b);
        check("R5 hold gap1", h, 2); check("R6 busy gap1", b, WR_CYC);
        model[0] = 8'h5A;
        rd_reg(A_CTL, d); check("R10 disarmed after write", int'(d), 0);
        do_write(9'd511, 8'hC3, 4, h, b);
        check("R8 hold gap4", h, 2); check("R8 busy gap4", b, WR_CYC);
        model[511] = 8'hC3;
        do_write(9'd256, 8'h11, 2, h, b); model[256] = 8'h11;
        do_write(9'd255, 8'h22, 3, h, b); model[255] = 8'h22;

        // R3, R4, R1: reads at distinct address bits
        do_read(9'd0, h, d);   check("R4 read hold", h, 4); check("R3 read 0", int'(d), 'h5A);
        do_read(9'd511, h, d); check("R3 read 511", int'(d), 'hC3);
        do_read(9'd256, h, d); check("R1 bit8 read", int'(d), 'h11);
        do_read(9'd255, h, d); check("R1 low read", int'(d), 'h22);

        // R8: strobe 5 cycles after guard is ignored
        do_write(9'd256, 8'h99, 5, h, b);
        check("R8 gap5 hold", h, 0); check("R8 gap5 busy", b, 0);
        do_read(9'd256, h, d); check("R8 gap5 array", int'(d), 'h11);

        // R7: strobe with no guard at all
        set_addr(9'd255);
        bus_wr(A_DAT, 8'h77);
        idle(6);
        bus_wr(A_CTL, 8'h02);
        measure(h, b);
        check("R7 hold", h, 0); check("R7 busy", b, 0);
        do_read(9'd255, h, d); check("R7 array", int'(d), 'h22);

        // R9, R6: strobes during busy
        set_addr(9'd165);
        bus_wr(A_DAT, 8'h77);
        bus_wr(A_CTL, 8'h04);
        bus_wr(A_CTL, 8'h02);
        model[165] = 8'h77;
        idle(4);
        set_addr(9'd256);
        bus_wr(A_CTL, 8'h01);
        check("R9 read hold", int'(cpu_hold), 0);
        idle(6);
        rd_reg(A_DAT, d); check("R9 data kept", int'(d), 'h77);
        bus_wr(A_DAT, 8'h99);
        bus_wr(A_CTL, 8'h04);
        bus_wr(A_CTL, 8'h02);
        check("R9 write hold", int'(cpu_hold), 0);
        for (int i = 0; i < WR_CYC + 4; i++) @(negedge clk);
        rd_reg(A_CTL, d); check("R9 busy done", int'(d[3]), 0);
        do_read(9'd256, h, d); check("R9 array kept", int'(d), 'h11);
        do_read(9'd165, h, d); check("R6 pending byte", int'(d), 'h77);

        // Random write/read pairs
        for (int it = 0; it < 20; it++) begin
            ra  = 9'($urandom_range(0, 511));
            rv  = 8'($urandom_range(0, 255));
            gap = int'($urandom_range(1, 4));
            do_write(ra, rv, gap, h, b);
            model[ra] = rv;
            check("R5 random hold", h, 2);
            check("R6 random busy", b, WR_CYC);
            do_read(ra, h, d);
            check("R4 random read hold", h, 4);
            check("R3 random read", int'(d), int'(model[ra]));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule